// File: doc/BRIEF.md
# Errored-Field Counter with Clear Modes

This block keeps a running tally of video fields that arrived with errors. At each end-of-field strobe it looks at the fifteen error flags of the outgoing packet. It masks them with a fifteen-bit sensitivity word. If any flag survives the mask, the tally advances by one. The tally is 24 bits wide and stops at all-ones instead of wrapping.

A two-bit mode register decides how the tally is cleared:

| Code | Mode |
|------|------|
| 00 | plain counting |
| 01 | single clear |
| 10 | counting, with a clear each time the host reads the low byte |
| 11 | held at zero |

The single-clear code resets itself, so a host can write it once and leave. With code 10, polling the low byte gives the number of errored fields since the previous poll. The tally is presented as three byte-wide outputs, one for each host-readable address.

Top module: `errfield_counter`

## Requirements
- R1: When `field_end` is high and `err_flags & sens_mask` is nonzero, the count rises by one at that clock edge. This holds in mode 00 and mode 10.
- R2: A flag whose sensitivity bit is 0 has no effect. Flags present without `field_end` have no effect either.
- R3: Mode encoding: 00 is normal counting, 01 is single clear, 10 is clear-on-low-byte-read, and 11 is hold-at-zero. A write (`mode_wr` high) loads `mode_wdata` at the clock edge.
- R4: While the mode is 01, the next edge sets the count to zero and the mode to 00. Counting then resumes. A field strobe in that cycle is not counted.
- R5: In mode 10, a read strobe (`rd_en`) with `rd_addr` equal to 17 zeroes the count at that edge. Reads of addresses 18 or 19 do not clear the count, and neither does any read in mode 00.
- R6: In mode 11 the count becomes zero and stays zero for as long as the mode remains 11.
- R7: When a clear-on-read and a counted field fall in the same cycle, the count goes to zero and the field is not counted.
- R8: The count saturates at its all-ones value and does not wrap.
- R9: The byte outputs are mapped as follows: `cnt_lo` is count bits [7:0] (address 17), `cnt_mid` is bits [15:8] (address 18), and `cnt_hi` is bits [23:16] (address 19).
- R10: A synchronous `rst` sets both the count and the mode to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| field_end | input | 1 | One-cycle strobe at the end of each field |
| err_flags | input | 15 | Error flags of the outgoing packet |
| sens_mask | input | 15 | Sensitivity bit per flag |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value to write |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| mode_q | output | 2 | Current mode |
| cnt_lo | output | 8 | Count bits [7:0] |
| cnt_mid | output | 8 | Count bits [15:8] |
| cnt_hi | output | 8 | Count bits [23:16] |

## Verification
Two pairs of events can meet in one clock cycle.

- A field strobe with an unmasked flag can coincide with a host read of address 17 while the mode is 10. The bench raises both in the same vector and expects zero rather than one more than the old count.
- A field strobe can land in the single cycle during which the mode reads 01. The bench expects a zero count and mode 00 after that edge, and it expects counting to resume only on the next field.

A mode write issued together with a field strobe is judged against the mode that was already in force during that cycle.

// File: rtl/errfield_counter.sv
module errfield_counter #(
  parameter int NFLAG   = 15,
  parameter int CNT_W   = 24,
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              field_end,
  input  logic [NFLAG-1:0]  err_flags,
  input  logic [NFLAG-1:0]  sens_mask,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        mode_q,
  output logic [7:0]        cnt_lo,
  output logic [7:0]        cnt_mid,
  output logic [7:0]        cnt_hi
);
  localparam logic [1:0]        M_NORM = 2'b00;
  localparam logic [1:0]        M_ONCE = 2'b01;
  localparam logic [1:0]        M_RDCL = 2'b10;
  localparam logic [1:0]        M_HOLD = 2'b11;
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_LO = LO_ADDR[ADDR_W-1:0];

  logic [CNT_W-1:0] cnt_q;
  logic [23:0]      cnt_wide;
  logic             hit, rd_clr, force_zero;

  assign hit        = field_end && |(err_flags & sens_mask);
  assign rd_clr     = (mode_q == M_RDCL) && rd_en && (rd_addr == A_LO);
  assign force_zero = (mode_q == M_ONCE) || (mode_q == M_HOLD) || rd_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_NORM;
    end else if (mode_wr) begin
      mode_q <= mode_wdata;
    end else if (mode_q == M_ONCE) begin
      mode_q <= M_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || force_zero) begin
      cnt_q <= '0;
    end else if (hit && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    cnt_wide = '0;
    cnt_wide[CNT_W-1:0] = cnt_q;
  end

  assign cnt_lo  = cnt_wide[7:0];
  assign cnt_mid = cnt_wide[15:8];
  assign cnt_hi  = cnt_wide[23:16];
endmodule

// File: rtl/errfield_counter_chk.sv
module errfield_counter_chk #(
  parameter int NFLAG   = 15,
  parameter int CNT_W   = 24,
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              field_end,
  input logic [NFLAG-1:0]  err_flags,
  input logic [NFLAG-1:0]  sens_mask,
  input logic              mode_wr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        mode_q,
  input logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic counted, lo_read, quiet;
  assign counted = field_end && (err_flags & sens_mask) != '0;
  assign lo_read = rd_en && rd_addr == LO_ADDR[ADDR_W-1:0];
  assign quiet   = mode_q == 2'b00 || (mode_q == 2'b10 && !lo_read);

  a_r1_increment: assert property (@(posedge clk) disable iff (rst)
    quiet && counted && cnt_q != TOP |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_no_hit_stable: assert property (@(posedge clk) disable iff (rst)
    quiet && !counted |=> $stable(cnt_q));
  a_r4_single_clear: assert property (@(posedge clk) disable iff (rst)
    mode_q == 2'b01 && !mode_wr |=> cnt_q == '0 && mode_q == 2'b00);
  a_r5_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
    mode_q == 2'b10 && lo_read |=> cnt_q == '0);
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
    mode_q == 2'b11 |=> cnt_q == '0);
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt_q == TOP && quiet |=> cnt_q == TOP);
endmodule

bind errfield_counter errfield_counter_chk #(
  .NFLAG(NFLAG), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .field_end(field_end), .err_flags(err_flags),
  .sens_mask(sens_mask), .mode_wr(mode_wr), .rd_en(rd_en), .rd_addr(rd_addr),
  .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/errfield_counter_bench.sv
`timescale 1ns/1ps
module errfield_counter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        field_end = 1'b0;
  logic [14:0] err_flags = '0;
  logic [14:0] sens_mask = '0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [1:0]  mode_q, n_mode;
  logic [7:0]  cnt_lo, cnt_mid, cnt_hi, n_lo, n_mid, n_hi;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  errfield_counter u_errfield_counter (
    .clk(clk), .rst(rst), .field_end(field_end), .err_flags(err_flags),
    .sens_mask(sens_mask), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .mode_q(mode_q),
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cnt_hi(cnt_hi));

  errfield_counter #(.CNT_W(4)) u_errfield_counter_narrow (
    .clk(clk), .rst(rst), .field_end(field_end), .err_flags(err_flags),
    .sens_mask(sens_mask), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .mode_q(n_mode),
    .cnt_lo(n_lo), .cnt_mid(n_mid), .cnt_hi(n_hi));

  typedef struct packed {
    logic        wr;
    logic [1:0]  wd;
    logic        fe;
    logic [14:0] fl;
    logic [14:0] mk;
    logic        rd;
    logic [7:0]  ad;
    logic [23:0] ecnt;
    logic [1:0]  emode;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd1, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h0002, 15'h0001, 1'b0, 8'd0,  24'd1, 2'd0},
    '{1'b0, 2'd0, 1'b0, 15'h7FFF, 15'h7FFF, 1'b0, 8'd0,  24'd1, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h4000, 15'h7FFF, 1'b0, 8'd0,  24'd2, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b1, 8'd17, 24'd3, 2'd0},
    '{1'b1, 2'd2, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd4, 2'd2},
    '{1'b0, 2'd0, 1'b1, 15'h0100, 15'h0100, 1'b1, 8'd18, 24'd5, 2'd2},
    '{1'b0, 2'd0, 1'b0, 15'h0000, 15'h0000, 1'b1, 8'd19, 24'd5, 2'd2},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b1, 8'd17, 24'd0, 2'd2},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd1, 2'd2},
    '{1'b1, 2'd3, 1'b0, 15'h0000, 15'h0000, 1'b0, 8'd0,  24'd1, 2'd3},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd0, 2'd3},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd0, 2'd3},
    '{1'b1, 2'd0, 1'b0, 15'h0000, 15'h0000, 1'b0, 8'd0,  24'd0, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd1, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd2, 2'd0},
    '{1'b1, 2'd1, 1'b0, 15'h0000, 15'h0000, 1'b0, 8'd0,  24'd2, 2'd1},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd0, 2'd0},
    '{1'b0, 2'd0, 1'b1, 15'h0001, 15'h0001, 1'b0, 8'd0,  24'd1, 2'd0}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    field_end = 1'b0; err_flags = '0; sens_mask = '0;
    mode_wr = 1'b0; mode_wdata = '0; rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      field_end = 1'b1; err_flags = 15'h0010; sens_mask = 15'h0010;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R10 reset count", {cnt_hi, cnt_mid, cnt_lo}, 24'd0);
    chk("R10 reset mode", {22'd0, mode_q}, 24'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_wr = VECS[v].wr; mode_wdata = VECS[v].wd; field_end = VECS[v].fe;
      err_flags = VECS[v].fl; sens_mask = VECS[v].mk;
      rd_en = VECS[v].rd; rd_addr = VECS[v].ad;
      @(posedge clk);
      #1;
      chk($sformatf("R1-R7 vec%0d count", v), {cnt_hi, cnt_mid, cnt_lo}, VECS[v].ecnt);
      chk($sformatf("R3 vec%0d mode", v), {22'd0, mode_q}, {22'd0, VECS[v].emode});
    end

    // R9: byte mapping, 259 = 0x000103
    do_reset();
    hits(259);
    chk("R9 low byte", {16'd0, cnt_lo}, 24'h03);
    chk("R9 mid byte", {16'd0, cnt_mid}, 24'h01);
    chk("R9 high byte", {16'd0, cnt_hi}, 24'h00);

    // R8: narrow instance saturates at 15
    do_reset();
    hits(20);
    chk("R8 narrow saturation", {n_hi, n_mid, n_lo}, 24'd15);
    chk("R1 wide count after 20", {cnt_hi, cnt_mid, cnt_lo}, 24'd20);

    // R5: mid/high reads in mode 10 leave count
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 2'd2;
    @(negedge clk); idle(); rd_en = 1'b1; rd_addr = 8'd19;
    @(negedge clk); rd_addr = 8'd18;
    @(negedge clk); idle();
    chk("R5 high/mid read keeps count", {cnt_hi, cnt_mid, cnt_lo}, 24'd20);
    rd_en = 1'b1; rd_addr = 8'd17;
    @(negedge clk); idle();
    chk("R5 low read clears", {cnt_hi, cnt_mid, cnt_lo}, 24'd0);

    // R10: reset clears mode and count
    hits(3);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 2'd3;
    @(negedge clk); idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 reset mid-run mode", {22'd0, mode_q}, 24'd0);
    chk("R10 reset mid-run count", {cnt_hi, cnt_mid, cnt_lo}, 24'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule